// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block sits at the decode/issue boundary of an in-order pipeline that feeds four execution units of unequal depth: a single-cycle integer unit, a four-stage pipelined floating-point adder, a seven-stage pipelined floating-point multiplier and a floating-point divider that is not pipelined and stays occupied for 24 cycles. Each cycle the decoder presents one candidate operation: its unit, two source registers and a destination register. The block either lets it go, raising the issue enable of the selected unit, or holds it with a stall.

Holding is needed for five reasons:
- a source is still being produced;
- the destination is still owed a result by an older operation;
- the single register-file write port is already claimed for the cycle the new operation would finish;
- the divider is occupied;
- the new operation would finish ahead of an older floating-point operation that may still fault.

The last rule keeps faults precise. Results are taken as forwardable in the cycle they are written back, so a consumer may issue in that cycle.

Top module: `fu_issue_interlock`

## Requirements
- R1: After reset no register is pending, no writeback is booked and the divider is idle, so the first valid operation issues without a stall, even one that reads a register that was pending before reset.
- R2: The unit code is 0 for integer, 1 for FP add, 2 for FP multiply and 3 for FP divide. When `issue_valid` is high and `stall` is low, exactly bit `issue_unit` of `issue_en` is set. When `issue_valid` is low, `stall` and `issue_en` are both zero and nothing changes state.
- R3: An operation issued in cycle c writes back in cycle c+L, with L = 1, 4, 7 or 24 by unit. A later operation reading its destination stalls through cycle c+L-1 and may issue in cycle c+L.
- R4: An operation whose destination is still pending from an older operation stalls (write-after-write), unless that older result is written back in the current cycle.
- R5: An operation stalls when another operation already in flight writes back in the same cycle that the new one would.
- R6: After a divide issues in cycle c, every divide presented in cycles c+1 to c+24 stalls, and a divide in cycle c+25 may issue.
- R7: Any operation stalls while an in-flight FP add, multiply or divide would write back later than the new operation would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | A decoded operation is presented |
| issue_unit | input | 2 | Target unit code (0 int, 1 add, 2 mul, 3 div) |
| src_a | input | 5 | First source register |
| src_b | input | 5 | Second source register |
| dst | input | 5 | Destination register |
| stall | output | 1 | Hold the presented operation in decode |
| issue_en | output | 4 | One-hot issue strobe per unit |

## Verification
`stall` and `issue_en` are combinational from the presented operation and from state registered at the previous edge. The bench drives each operation at a falling edge and samples both outputs shortly after, before the next rising edge. An operation's writeback then counts from the rising edge that accepts it: a reader of its result is expected to stall for L-1 cycles and to go in the L-th. Each vector in the stimulus table is placed at an exact cycle number, so the expected stall follows from counting edges since the producing issue. The divider window is walked one cycle at a time, with a stall expected in each of the 24 cycles after a divide and an issue in the 25th.

// File: rtl/fu_issue_pkg.sv
package fu_issue_pkg;

    localparam int NUM_UNITS = 4;

    typedef enum logic [1:0] {
        UNIT_INT  = 2'd0,
        UNIT_FADD = 2'd1,
        UNIT_FMUL = 2'd2,
        UNIT_FDIV = 2'd3
    } unit_e;

    // reasons that can hold an operation in decode
    typedef struct packed {
        logic raw;
        logic waw;
        logic port;
        logic order;
        logic div_busy;
    } hazard_t;

    function automatic int unit_latency(unit_e u, int li, int la, int lm, int ld);
        case (u)
            UNIT_INT:  return li;
            UNIT_FADD: return la;
            UNIT_FMUL: return lm;
            default:   return ld;
        endcase
    endfunction

endpackage

// File: rtl/wb_reservation.sv
module wb_reservation #(
    parameter int RES_LEN = 25,
    parameter int REG_W   = 5,
    localparam int LAT_W  = $clog2(RES_LEN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               book,
    input  logic               book_fp,
    input  logic [LAT_W-1:0]   book_lat,
    input  logic [REG_W-1:0]   book_dst,
    output logic [RES_LEN-1:0] slot_busy,
    output logic [RES_LEN-1:0] slot_fp,
    output logic               wb_now,
    output logic [REG_W-1:0]   wb_dst
);
    // bit k: a writeback happens k cycles from now
    logic [RES_LEN-1:0] busy_q, fp_q;
    logic [REG_W-1:0]   tag_q [RES_LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            fp_q   <= '0;
            for (int k = 0; k < RES_LEN; k++) tag_q[k] <= '0;
        end else begin
            busy_q <= busy_q >> 1;
            fp_q   <= fp_q >> 1;
            for (int k = 0; k < RES_LEN - 1; k++) tag_q[k] <= tag_q[k+1];
            tag_q[RES_LEN-1] <= '0;
            if (book) begin
                busy_q[book_lat - 1'b1] <= 1'b1;
                fp_q[book_lat - 1'b1]   <= book_fp;
                tag_q[book_lat - 1'b1]  <= book_dst;
            end
        end
    end

    assign slot_busy = busy_q;
    assign slot_fp   = fp_q;
    assign wb_now    = busy_q[0];
    assign wb_dst    = tag_q[0];
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
    parameter int NUM_REGS = 32,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  logic [REG_W-1:0]    set_idx,
    input  logic                clr_en,
    input  logic [REG_W-1:0]    clr_idx,
    output logic [NUM_REGS-1:0] pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else begin
            if (clr_en) pending[clr_idx] <= 1'b0;
            // a new claim wins over a retirement of the same register
            if (set_en) pending[set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/div_occupancy.sv
module div_occupancy #(
    parameter int BUSY_CYC = 24,
    localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (start)      cnt_q <= CNT_W'(BUSY_CYC);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != 0);
endmodule

// File: rtl/fu_issue_interlock.sv
module fu_issue_interlock
    import fu_issue_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int LAT_INT  = 1,
    parameter int LAT_ADD  = 4,
    parameter int LAT_MUL  = 7,
    parameter int LAT_DIV  = 24,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int RES_LEN = LAT_DIV + 1,
    localparam int LAT_W   = $clog2(RES_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_valid,
    input  logic [1:0]           issue_unit,
    input  logic [REG_W-1:0]     src_a,
    input  logic [REG_W-1:0]     src_b,
    input  logic [REG_W-1:0]     dst,
    output logic                 stall,
    output logic [NUM_UNITS-1:0] issue_en
);
    unit_e              unit;
    logic [LAT_W-1:0]   req_lat;
    logic               req_fp;
    logic               fire;
    logic [RES_LEN-1:0] slot_busy, slot_fp, later_mask;
    logic               wb_now;
    logic [REG_W-1:0]   wb_dst;
    logic [NUM_REGS-1:0] pending;
    logic               div_busy;
    hazard_t            hz;

    assign unit    = unit_e'(issue_unit);
    assign req_lat = LAT_W'(unit_latency(unit, LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV));
    assign req_fp  = (unit != UNIT_INT);

    // a register is usable if idle or retiring this cycle (forwarded)
    function automatic logic reg_busy(logic [REG_W-1:0] r, logic [NUM_REGS-1:0] pend,
                                      logic wbv, logic [REG_W-1:0] wbr);
        return pend[r] && !(wbv && (wbr == r));
    endfunction

    always_comb begin
        for (int k = 0; k < RES_LEN; k++) later_mask[k] = (LAT_W'(k) > req_lat);
    end

    always_comb begin
        hz.raw      = reg_busy(src_a, pending, wb_now, wb_dst) ||
                      reg_busy(src_b, pending, wb_now, wb_dst);
        hz.waw      = reg_busy(dst, pending, wb_now, wb_dst);
        hz.port     = slot_busy[req_lat];
        hz.order    = |(slot_fp & later_mask);
        hz.div_busy = (unit == UNIT_FDIV) && div_busy;
    end

    assign stall = issue_valid && (|hz);
    assign fire  = issue_valid && !stall;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_en
        assign issue_en[g] = fire && (issue_unit == 2'(g));
    end

    wb_reservation #(.RES_LEN(RES_LEN), .REG_W(REG_W)) u_resv (
        .clk(clk), .rst(rst),
        .book(fire), .book_fp(req_fp), .book_lat(req_lat), .book_dst(dst),
        .slot_busy(slot_busy), .slot_fp(slot_fp),
        .wb_now(wb_now), .wb_dst(wb_dst)
    );

    reg_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
        .clk(clk), .rst(rst),
        .set_en(fire), .set_idx(dst),
        .clr_en(wb_now), .clr_idx(wb_dst),
        .pending(pending)
    );

    div_occupancy #(.BUSY_CYC(LAT_DIV)) u_div (
        .clk(clk), .rst(rst),
        .start(issue_en[UNIT_FDIV]),
        .busy(div_busy)
    );
endmodule

// File: rtl/fu_issue_interlock_chk.sv
module fu_issue_interlock_chk #(
    parameter int LAT_INT  = 1,
    parameter int LAT_ADD  = 4,
    parameter int LAT_MUL  = 7,
    parameter int LAT_DIV  = 24,
    localparam int RES_LEN = LAT_DIV + 1,
    localparam int CNT_W   = $clog2(RES_LEN + 2)
) (
    input logic       clk,
    input logic       rst,
    input logic       issue_valid,
    input logic       stall,
    input logic [3:0] issue_en
);
    logic [RES_LEN-1:0] wb_mdl;
    logic [CNT_W-1:0]   since_div;
    int                 lat_sel;

    always_comb begin
        lat_sel = LAT_INT;
        if (issue_en[1]) lat_sel = LAT_ADD;
        if (issue_en[2]) lat_sel = LAT_MUL;
        if (issue_en[3]) lat_sel = LAT_DIV;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_mdl    <= '0;
            since_div <= CNT_W'(RES_LEN + 1);
        end else begin
            wb_mdl <= (wb_mdl >> 1) |
                      ((|issue_en) ? (RES_LEN'(1) << (lat_sel - 1)) : '0);
            if (issue_en[3])                    since_div <= CNT_W'(1);
            else if (since_div < CNT_W'(RES_LEN + 1)) since_div <= since_div + 1'b1;
        end
    end

    AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_en)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> (!stall && issue_en == 4'b0)); // R2
    AST_WB_PORT_FREE: assert property (@(posedge clk) disable iff (rst)
        (|issue_en) |-> !wb_mdl[lat_sel]); // R5
    AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
        issue_en[3] |-> (since_div >= CNT_W'(RES_LEN))); // R6
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && issue_valid) |-> !stall); // R1
endmodule

bind fu_issue_interlock fu_issue_interlock_chk #(
    .LAT_INT(LAT_INT), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
) u_chk (
    .clk(clk), .rst(rst), .issue_valid(issue_valid),
    .stall(stall), .issue_en(issue_en)
);

// File: tb/sim_fu_issue_interlock.sv
`timescale 1ns/1ps
module sim_fu_issue_interlock;
    logic       clk = 1'b0;
    logic       rst;
    logic       issue_valid;
    logic [1:0] issue_unit;
    logic [4:0] src_a, src_b, dst;
    logic       stall;
    logic [3:0] issue_en;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    fu_issue_interlock u0 (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_unit(issue_unit),
        .src_a(src_a), .src_b(src_b), .dst(dst), .stall(stall), .issue_en(issue_en)
    );

    // {valid, unit, src_a, src_b, dst, expected stall}; entry i runs in cycle i
    localparam int NV = 16;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 2'd0, 5'd1,  5'd2,  5'd3,  1'b0},  // 0  int writes r3
        {1'b1, 2'd0, 5'd3,  5'd4,  5'd5,  1'b0},  // 1  reads r3 in its wb cycle
        {1'b1, 2'd2, 5'd6,  5'd7,  5'd8,  1'b0},  // 2  mul r8, wb cycle 9
        {1'b1, 2'd1, 5'd8,  5'd1,  5'd9,  1'b1},  // 3  RAW on r8
        {1'b1, 2'd1, 5'd1,  5'd2,  5'd10, 1'b1},  // 4  would finish before mul
        {1'b1, 2'd1, 5'd1,  5'd2,  5'd10, 1'b1},  // 5  same wb cycle as mul
        {1'b1, 2'd1, 5'd1,  5'd2,  5'd10, 1'b0},  // 6  add r10, wb cycle 10
        {1'b1, 2'd0, 5'd1,  5'd2,  5'd11, 1'b1},  // 7  int ahead of FP ops
        {1'b1, 2'd0, 5'd1,  5'd2,  5'd11, 1'b1},  // 8  port taken by mul
        {1'b1, 2'd0, 5'd1,  5'd2,  5'd11, 1'b1},  // 9  port taken by add
        {1'b1, 2'd1, 5'd8,  5'd10, 5'd12, 1'b0},  // 10 r8 retired, r10 forwarded
        {1'b1, 2'd2, 5'd1,  5'd2,  5'd12, 1'b1},  // 11 WAW on r12
        {1'b1, 2'd3, 5'd1,  5'd2,  5'd13, 1'b0},  // 12 divide starts
        {1'b1, 2'd3, 5'd1,  5'd2,  5'd14, 1'b1},  // 13 divider occupied
        {1'b0, 2'd0, 5'd1,  5'd2,  5'd3,  1'b0},  // 14 nothing presented
        {1'b1, 2'd0, 5'd13, 5'd1,  5'd15, 1'b1}   // 15 RAW on divide result
    };

    function automatic string vec_tag(int i);
        case (i)
            3, 10, 15:  return "R3";
            4, 7:       return "R7";
            5, 8, 9:    return "R5";
            11:         return "R4";
            13:         return "R6";
            14:         return "R2";
            default:    return "R3";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic drive(logic v, logic [1:0] u, logic [4:0] a, logic [4:0] b, logic [4:0] d);
        issue_valid = v; issue_unit = u; src_a = a; src_b = b; dst = d;
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            logic [3:0]  exp_en;
            v = VEC[i];
            drive(v[18], v[17:16], v[15:11], v[10:6], v[5:1]);
            exp_en = (v[18] && !v[0]) ? (4'b0001 << v[17:16]) : 4'b0000;
            #2;
            chk($sformatf("%s v%0d stall", vec_tag(i), i), 32'(stall), 32'(v[0]));
            chk($sformatf("R2 v%0d issue_en", i), 32'(issue_en), 32'(exp_en));
            @(negedge clk);
        end

        // R1: reset in the middle of activity clears everything
        rst = 1'b1;
        drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1 idle stall", 32'(stall), 32'd0);
        chk("R1 idle issue_en", 32'(issue_en), 32'd0);
        drive(1'b1, 2'd0, 5'd13, 5'd1, 5'd22);
        #2;
        chk("R1 r13 released by reset", 32'(stall), 32'd0);
        chk("R1 int issues", 32'(issue_en), 32'b0001);
        @(negedge clk);

        // R6: divider occupancy window
        drive(1'b1, 2'd3, 5'd1, 5'd2, 5'd20);
        #2;
        chk("R6 first divide", 32'(issue_en), 32'b1000);
        @(negedge clk);
        for (int k = 1; k <= 24; k++) begin
            drive(1'b1, 2'd3, 5'd1, 5'd2, 5'd21);
            #2;
            chk($sformatf("R6 divide held at +%0d", k), 32'(stall), 32'd1);
            @(negedge clk);
        end
        #2;
        chk("R6 divide at +25 stall", 32'(stall), 32'd0);
        chk("R6 divide at +25 issue_en", 32'(issue_en), 32'b1000);
        @(negedge clk);
        drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule